// File: doc/BRIEF.md
# Radio Transceiver Boot Sequencer over SPI

This block brings a radio transceiver out of reset by writing its configuration registers over a four-wire serial link. When `begin_config` is pulsed, it walks an internal table of boot words in index order. Each 24-bit word becomes one register write framed by a single chip-select window: an 8-bit register address, then 16 data bits. When the last word has gone out and the trailing chip-select gap has elapsed, `done_config` goes high and stays high.

Between boot sequences the block also accepts single-byte command strobes on a valid/ready input. A strobe is sent as an 8-bit transfer in its own chip-select window. In every transfer, the first byte the transceiver returns on its serial output is captured and presented as a status byte, flagged by a one-cycle `status_valid` pulse.

The serial clock is divided down from the system clock. With the default divide of 5 and a 50 MHz system clock it runs at 10 MHz, with 3 cycles low and 2 cycles high. The data line changes on the falling serial-clock edge, and the returned line is sampled on the rising edge.

Top module: `spicfg_seq`

## Requirements
- R1: Out of reset `spi_csn` is 1, `spi_sclk` is 0, `done_config` is 0, `status_valid` is 0 and `cmd_ready` is 1.
- R2: `begin_config` sampled high while idle pulls `spi_csn` low in the next cycle. The block then sends ROM_DEPTH words in index order 0, 1, 2, and so on. Word i is `{8'h10+i, 8'hC0|i, 8'h3C ^ (8'h01 << i)}` for i = 0..7.
- R3: A boot word is 24 bits sent MSB first, with `spi_csn` held low from the first bit to the last. A command strobe is the 8 bits of `cmd_data` sent MSB first in a separate window. `spi_mosi` never changes while `spi_sclk` is high.
- R4: While `spi_csn` is low, `spi_sclk` is low for CLK_DIV-CLK_DIV/2 cycles before each rising edge and high for CLK_DIV/2 cycles. The first low phase starts in the cycle `spi_csn` falls. While `spi_csn` is high, `spi_sclk` is 0.
- R5: `spi_csn` stays high for at least CLK_DIV cycles between transfers, and for exactly CLK_DIV cycles between words of one boot sequence.
- R6: `done_config` rises exactly CLK_DIV cycles after `spi_csn` rises at the end of the last boot word. It stays high, including through later command strobes, until `begin_config` is accepted, which clears it in the cycle `spi_csn` falls.
- R7: A command is taken on `cmd_valid && cmd_ready`, and `spi_csn` falls in the next cycle. `cmd_ready` is 0 in any cycle where `begin_config` is 1, so a boot request wins over a simultaneous command.
- R8: `status_valid` pulses for exactly one cycle: the cycle in which `spi_sclk` first shows high for the eighth bit of a transfer. In that cycle `status_byte` holds the first 8 bits sampled from `spi_miso`, MSB first.
- R9: `begin_config` pulsed while a sequence or strobe is in progress is ignored. No extra transfers follow.
- R10: `cmd_ready` is 0 whenever a transfer or its trailing gap is in progress. A command held valid during that time is neither lost nor duplicated, and is sent once the block is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| begin_config | input | 1 | Start the boot sequence (sampled when idle) |
| done_config | output | 1 | Boot sequence complete, held until the next start |
| cmd_valid | input | 1 | Command strobe byte offered |
| cmd_ready | output | 1 | Block idle and able to take a command |
| cmd_data | input | 8 | Command strobe byte |
| status_byte | output | 8 | First byte returned in the latest transfer |
| status_valid | output | 1 | One-cycle flag for a new `status_byte` |
| spi_csn | output | 1 | Active-low chip select |
| spi_sclk | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data to the transceiver |
| spi_miso | input | 1 | Serial data from the transceiver |

## Verification
Each result has a fixed latency. `spi_csn` must be low in the first cycle after a start or command handshake. `status_valid` must coincide with the eighth rising serial-clock level. `done_config` must follow the last chip-select rise by exactly CLK_DIV cycles. The bench samples every output on the falling system-clock edge and keeps running counts of low, high and deselected cycles, so every edge is checked in the exact cycle it is due rather than inside a tolerance window. A behavioural transceiver model returns a different status byte per transfer and compares each completed frame against a queue of expected words filled by the stimulus.

// File: rtl/spicfg_pkg.sv
package spicfg_pkg;

  localparam int ADDR_W   = 8;
  localparam int DATA_W   = 16;
  localparam int WORD_W   = ADDR_W + DATA_W;
  localparam int STROBE_W = 8;
  localparam int STAT_W   = 8;

  typedef enum logic [1:0] {
    SQ_IDLE,
    SQ_SHIFT,
    SQ_TAIL,
    SQ_GAP
  } seq_state_e;

  // Boot word for table slot idx: register address, then data high, then data low.
  function automatic logic [WORD_W-1:0] boot_word(input int unsigned idx);
    logic [7:0] reg_addr;
    logic [7:0] val_hi;
    logic [7:0] val_lo;
    reg_addr = 8'(32'h10 + idx);
    val_hi   = 8'hC0 | 8'(idx);
    val_lo   = 8'h3C ^ (8'h01 << (idx % 8));
    return {reg_addr, val_hi, val_lo};
  endfunction

endpackage

// File: rtl/spicfg_rom.sv
module spicfg_rom
  import spicfg_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic [IDX_W-1:0]  sel,
  output logic [WORD_W-1:0] word
);

  logic [WORD_W-1:0] slot_w [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    assign slot_w[g] = boot_word(g);
  end

  assign word = slot_w[sel];

endmodule

// File: rtl/spicfg_sclk_gen.sv
module spicfg_sclk_gen #(
  parameter int DIV = 5,
  localparam int HI_CYC = DIV / 2,
  localparam int LO_CYC = DIV - HI_CYC,
  localparam int PH_W   = $clog2(DIV)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic sclk,
  output logic rise,
  output logic fall
);

  logic [PH_W-1:0] phase_q;

  assign rise = run && (phase_q == PH_W'(LO_CYC - 1));
  assign fall = run && (phase_q == PH_W'(DIV - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= '0;
      sclk    <= 1'b0;
    end else if (!run) begin
      phase_q <= '0;
      sclk    <= 1'b0;
    end else begin
      phase_q <= fall ? '0 : phase_q + PH_W'(1);
      if (rise)      sclk <= 1'b1;
      else if (fall) sclk <= 1'b0;
    end
  end

endmodule

// File: rtl/spicfg_shifter.sv
module spicfg_shifter
  import spicfg_pkg::*;
#(
  parameter int MAX_BITS = WORD_W,
  parameter int RX_W     = STAT_W,
  localparam int LEN_W   = $clog2(MAX_BITS + 1),
  localparam int RXC_W   = $clog2(RX_W + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                load,
  input  logic [MAX_BITS-1:0] load_data,
  input  logic [LEN_W-1:0]    load_len,
  input  logic                rise,
  input  logic                fall,
  input  logic                miso,
  output logic                mosi,
  output logic                last,
  output logic [RX_W-1:0]     status,
  output logic                status_valid
);

  logic [MAX_BITS-1:0] tx_q;
  logic [LEN_W-1:0]    sent_q;
  logic [LEN_W-1:0]    len_q;
  logic [RX_W-1:0]     rx_q;
  logic [RXC_W-1:0]    got_q;

  assign mosi = tx_q[MAX_BITS-1];
  assign last = fall && (sent_q == len_q - LEN_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_q   <= '0;
      sent_q <= '0;
      len_q  <= '0;
    end else if (load) begin
      tx_q   <= load_data;
      sent_q <= '0;
      len_q  <= load_len;
    end else if (fall) begin
      tx_q   <= {tx_q[MAX_BITS-2:0], 1'b0};
      sent_q <= sent_q + LEN_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_q         <= '0;
      got_q        <= '0;
      status       <= '0;
      status_valid <= 1'b0;
    end else begin
      status_valid <= 1'b0;
      if (load) begin
        got_q <= '0;
      end else if (rise && (got_q < RXC_W'(RX_W))) begin
        rx_q  <= {rx_q[RX_W-2:0], miso};
        got_q <= got_q + RXC_W'(1);
        if (got_q == RXC_W'(RX_W - 1)) begin
          status       <= {rx_q[RX_W-2:0], miso};
          status_valid <= 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/spicfg_seq.sv
module spicfg_seq
  import spicfg_pkg::*;
#(
  parameter int CLK_DIV   = 5,
  parameter int ROM_DEPTH = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              begin_config,
  output logic              done_config,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [STROBE_W-1:0] cmd_data,
  output logic [STAT_W-1:0] status_byte,
  output logic              status_valid,
  output logic              spi_csn,
  output logic              spi_sclk,
  output logic              spi_mosi,
  input  logic              spi_miso
);

  localparam int SCLK_HI = CLK_DIV / 2;
  localparam int SCLK_LO = CLK_DIV - SCLK_HI;
  localparam int IDX_W   = (ROM_DEPTH > 1) ? $clog2(ROM_DEPTH) : 1;
  localparam int CNT_W   = $clog2(CLK_DIV);
  localparam int LEN_W   = $clog2(WORD_W + 1);

  seq_state_e        state_q;
  logic [CNT_W-1:0]  wait_q;
  logic [IDX_W-1:0]  idx_q;
  logic              cfg_q;
  logic              done_q;
  logic              csn_q;

  logic              run, rise, fall, last;
  logic              start_cfg, take_cmd, more, tail_end, gap_end, load;
  logic [IDX_W-1:0]  rom_sel;
  logic [WORD_W-1:0] rom_word, load_data;
  logic [LEN_W-1:0]  load_len;

  assign run       = (state_q == SQ_SHIFT);
  assign start_cfg = (state_q == SQ_IDLE) && begin_config;
  assign cmd_ready = (state_q == SQ_IDLE) && !begin_config;
  assign take_cmd  = cmd_valid && cmd_ready;
  assign more      = cfg_q && (idx_q != IDX_W'(ROM_DEPTH - 1));
  assign tail_end  = (state_q == SQ_TAIL) && (wait_q == CNT_W'(SCLK_LO - 1));
  assign gap_end   = (state_q == SQ_GAP)  && (wait_q == CNT_W'(CLK_DIV - 1));
  assign load      = start_cfg || take_cmd || (gap_end && more);
  assign rom_sel   = start_cfg ? '0 : idx_q + IDX_W'(1);
  assign load_data = take_cmd ? {cmd_data, {DATA_W{1'b0}}} : rom_word;
  assign load_len  = take_cmd ? LEN_W'(STROBE_W) : LEN_W'(WORD_W);

  assign done_config = done_q;
  assign spi_csn     = csn_q;

  spicfg_rom #(.DEPTH(ROM_DEPTH)) u_rom (
    .sel  (rom_sel),
    .word (rom_word)
  );

  spicfg_sclk_gen #(.DIV(CLK_DIV)) u_sclk (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (run),
    .sclk  (spi_sclk),
    .rise  (rise),
    .fall  (fall)
  );

  spicfg_shifter #(.MAX_BITS(WORD_W), .RX_W(STAT_W)) u_shift (
    .clk          (clk),
    .rst_n        (rst_n),
    .load         (load),
    .load_data    (load_data),
    .load_len     (load_len),
    .rise         (rise),
    .fall         (fall),
    .miso         (spi_miso),
    .mosi         (spi_mosi),
    .last         (last),
    .status       (status_byte),
    .status_valid (status_valid)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SQ_IDLE;
      wait_q  <= '0;
      idx_q   <= '0;
      cfg_q   <= 1'b0;
      done_q  <= 1'b0;
      csn_q   <= 1'b1;
    end else begin
      unique case (state_q)
        SQ_IDLE: begin
          if (start_cfg) begin
            state_q <= SQ_SHIFT;
            csn_q   <= 1'b0;
            idx_q   <= '0;
            cfg_q   <= 1'b1;
            done_q  <= 1'b0;
          end else if (take_cmd) begin
            state_q <= SQ_SHIFT;
            csn_q   <= 1'b0;
            cfg_q   <= 1'b0;
          end
        end
        SQ_SHIFT: begin
          if (last) begin
            state_q <= SQ_TAIL;
            wait_q  <= '0;
          end
        end
        SQ_TAIL: begin
          if (tail_end) begin
            state_q <= SQ_GAP;
            csn_q   <= 1'b1;
            wait_q  <= '0;
          end else begin
            wait_q <= wait_q + CNT_W'(1);
          end
        end
        SQ_GAP: begin
          if (gap_end) begin
            wait_q <= '0;
            if (more) begin
              state_q <= SQ_SHIFT;
              csn_q   <= 1'b0;
              idx_q   <= idx_q + IDX_W'(1);
            end else begin
              state_q <= SQ_IDLE;
              if (cfg_q) done_q <= 1'b1;
            end
          end else begin
            wait_q <= wait_q + CNT_W'(1);
          end
        end
        default: state_q <= SQ_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/spicfg_seq_chk.sv
module spicfg_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic begin_config,
  input logic done_config,
  input logic cmd_ready,
  input logic status_valid,
  input logic spi_csn,
  input logic spi_sclk,
  input logic spi_mosi
);

  assert_sclk_parked_R4: assert property (@(posedge clk) disable iff (!rst_n)
    spi_csn |-> !spi_sclk);

  assert_mosi_steady_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (spi_sclk && $past(spi_sclk)) |-> $stable(spi_mosi));

  assert_status_on_rise_R8: assert property (@(posedge clk) disable iff (!rst_n)
    status_valid |-> $rose(spi_sclk));

  assert_ready_when_deselected_R10: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ready |-> spi_csn);

  assert_boot_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
    begin_config |-> !cmd_ready);

  assert_done_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (done_config && !begin_config) |=> done_config);

  assert_done_deselected_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_config) |-> spi_csn);

  assert_select_starts_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(spi_csn) |-> !spi_sclk);

endmodule

bind spicfg_seq spicfg_seq_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .begin_config (begin_config),
  .done_config  (done_config),
  .cmd_ready    (cmd_ready),
  .status_valid (status_valid),
  .spi_csn      (spi_csn),
  .spi_sclk     (spi_sclk),
  .spi_mosi     (spi_mosi)
);

// File: tb/spicfg_seq_tb.sv
module spicfg_seq_tb;

  localparam int DIV   = 5;
  localparam int HI    = DIV / 2;
  localparam int LO    = DIV - HI;
  localparam int DEPTH = 8;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       begin_config;
  logic       done_config;
  logic       cmd_valid;
  logic       cmd_ready;
  logic [7:0] cmd_data;
  logic [7:0] status_byte;
  logic       status_valid;
  logic       spi_csn;
  logic       spi_sclk;
  logic       spi_mosi;
  logic       spi_miso = 1'b0;

  always #10 clk = ~clk;

  spicfg_seq #(.CLK_DIV(DIV), .ROM_DEPTH(DEPTH)) u_dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .begin_config (begin_config),
    .done_config  (done_config),
    .cmd_valid    (cmd_valid),
    .cmd_ready    (cmd_ready),
    .cmd_data     (cmd_data),
    .status_byte  (status_byte),
    .status_valid (status_valid),
    .spi_csn      (spi_csn),
    .spi_sclk     (spi_sclk),
    .spi_mosi     (spi_mosi),
    .spi_miso     (spi_miso)
  );

  int checks = 0;
  int fails  = 0;
  int exp_word[$];
  int exp_len[$];
  int pushed = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic int ref_word(input int i);
    return ((16 + i) << 16) | ((8'hC0 | i) << 8) | (8'h3C ^ ((1 << i) & 8'hFF));
  endfunction

  function automatic int slave_byte(input int f);
    return (f * 37 + 5) & 8'hFF;
  endfunction

  // transceiver model and per-cycle monitor
  logic prev_csn = 1'b1, prev_sclk = 1'b0, prev_done = 1'b0;
  int   lo_run = 0, hi_run = 0, desel_run = 0;
  int   rx_val = 0, rx_bits = 0, frame_no = 0, cur_status = 0, cfg_seen = 0;
  logic [7:0] miso_sr = '0;

  always @(negedge clk) begin
    if (!rst_n) begin
      prev_csn  = 1'b1;
      prev_sclk = 1'b0;
      prev_done = 1'b0;
    end else begin
      bit ev_cfall, ev_crise, ev_rise, ev_fall, exp_sv;
      ev_cfall = prev_csn && !spi_csn;
      ev_crise = !prev_csn && spi_csn;
      ev_rise  = !spi_csn && !prev_sclk && spi_sclk;
      ev_fall  = !spi_csn && prev_sclk && !spi_sclk;
      exp_sv   = 1'b0;

      if (spi_csn) check(!spi_sclk, "R4", "sclk while deselected", spi_sclk, 0);

      if (ev_cfall) begin
        if (frame_no > 0) begin
          if (exp_len.size() > 0 && exp_len[0] == 24 && (cfg_seen % DEPTH) != 0)
            check(desel_run == DIV, "R5", "gap inside boot sequence", desel_run, DIV);
          else
            check(desel_run >= DIV, "R5", "gap between transfers", desel_run, DIV);
        end
        check(!spi_sclk, "R4", "sclk at select", spi_sclk, 0);
        rx_val     = 0;
        rx_bits    = 0;
        cur_status = slave_byte(frame_no);
        miso_sr    = 8'(cur_status);
        spi_miso   = miso_sr[7];
        lo_run     = 0;
      end

      if (ev_rise) begin
        check(lo_run == LO, "R4", "sclk low phase", lo_run, LO);
        rx_val  = (rx_val << 1) | int'(spi_mosi);
        rx_bits = rx_bits + 1;
        hi_run  = 0;
        if (rx_bits == 8) exp_sv = 1'b1;
      end

      check(status_valid == exp_sv, "R8", "status_valid timing", status_valid, exp_sv);
      if (exp_sv)
        check(status_byte == 8'(cur_status), "R8", "status byte", status_byte, cur_status);

      if (ev_fall) begin
        check(hi_run == HI, "R4", "sclk high phase", hi_run, HI);
        miso_sr  = {miso_sr[6:0], 1'b0};
        spi_miso = miso_sr[7];
        lo_run   = 0;
      end

      if (ev_crise) begin
        if (exp_word.size() == 0) begin
          check(1'b0, "R9", "unexpected transfer", rx_val, 0);
        end else begin
          int w, l;
          w = exp_word.pop_front();
          l = exp_len.pop_front();
          check(rx_bits == l, "R3", "frame length", rx_bits, l);
          check(rx_val == w, (l == 24) ? "R2" : "R3", "frame content", rx_val, w);
          if (l == 24) cfg_seen++;
        end
        frame_no++;
        desel_run = 0;
      end

      if (!prev_done && done_config) begin
        check(desel_run == DIV, "R6", "done delay after last word", desel_run, DIV);
        check(exp_word.size() == 0, "R6", "words left at done", exp_word.size(), 0);
      end

      if (!spi_csn) begin
        if (spi_sclk) hi_run++;
        else          lo_run++;
      end
      if (spi_csn) desel_run++;
      else         desel_run = 0;

      prev_csn  = spi_csn;
      prev_sclk = spi_sclk;
      prev_done = done_config;
    end
  end

  task automatic push_boot();
    for (int i = 0; i < DEPTH; i++) begin
      exp_word.push_back(ref_word(i));
      exp_len.push_back(24);
    end
    pushed += DEPTH;
  endtask

  task automatic push_cmd(input logic [7:0] d);
    exp_word.push_back(int'(d));
    exp_len.push_back(8);
    pushed++;
  endtask

  task automatic start_boot();
    @(negedge clk);
    begin_config = 1'b1;
    #1;
    check(!cmd_ready, "R7", "ready during start", cmd_ready, 0);
    push_boot();
    @(negedge clk);
    begin_config = 1'b0;
    check(!spi_csn, "R2", "select one cycle after start", spi_csn, 0);
    check(!done_config, "R6", "done cleared by start", done_config, 0);
  endtask

  task automatic send_cmd(input logic [7:0] d);
    @(negedge clk);
    cmd_valid = 1'b1;
    cmd_data  = d;
    #1;
    while (!cmd_ready) begin
      @(negedge clk);
      #1;
    end
    push_cmd(d);
    @(negedge clk);
    cmd_valid = 1'b0;
    check(!spi_csn, "R7", "select one cycle after handshake", spi_csn, 0);
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (exp_word.size() != 0 || !cmd_ready) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  task automatic run_all();
    rst_n = 1'b0; begin_config = 1'b0; cmd_valid = 1'b0; cmd_data = '0;
    repeat (3) @(negedge clk);
    check(spi_csn == 1'b1, "R1", "reset csn", spi_csn, 1);
    check(spi_sclk == 1'b0, "R1", "reset sclk", spi_sclk, 0);
    check(done_config == 1'b0, "R1", "reset done", done_config, 0);
    check(status_valid == 1'b0, "R1", "reset status_valid", status_valid, 0);
    check(cmd_ready == 1'b1, "R1", "reset ready", cmd_ready, 1);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // boot, a second start mid-way, and a command held through the sequence
    start_boot();
    repeat (300) @(negedge clk);
    begin_config = 1'b1;
    #1;
    check(!cmd_ready, "R10", "ready while busy", cmd_ready, 0);
    @(negedge clk);
    begin_config = 1'b0;
    send_cmd(8'hA7);
    check(done_config == 1'b1, "R6", "done held at command", done_config, 1);
    wait_idle();
    check(done_config == 1'b1, "R6", "done held after command", done_config, 1);
    repeat (200) @(negedge clk);
    check(frame_no == pushed, "R9", "transfer count after busy start", frame_no, pushed);
    check(frame_no == DEPTH + 1, "R10", "held command sent once", frame_no, DEPTH + 1);

    // start and command offered in the same cycle
    @(negedge clk);
    begin_config = 1'b1;
    cmd_valid    = 1'b1;
    cmd_data     = 8'h3E;
    #1;
    check(!cmd_ready, "R7", "start beats command", cmd_ready, 0);
    push_boot();
    @(negedge clk);
    begin_config = 1'b0;
    check(!done_config, "R6", "done cleared by restart", done_config, 0);
    #1;
    while (!cmd_ready) begin
      @(negedge clk);
      #1;
    end
    push_cmd(8'h3E);
    @(negedge clk);
    cmd_valid = 1'b0;
    check(!spi_csn, "R7", "deferred command starts", spi_csn, 0);
    wait_idle();

    // strobe patterns
    send_cmd(8'h00);
    send_cmd(8'hFF);
    send_cmd(8'h5A);
    wait_idle();
    repeat (50) @(negedge clk);
    check(frame_no == pushed, "R9", "final transfer count", frame_no, pushed);
  endtask

  initial begin
    fork
      run_all();
      begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL R2 watchdog: actual timeout expected completion");
      end
    join_any
    disable fork;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule